// File: doc/BRIEF.md
# NAND Flash Strobe Timing Sequencer

This block turns a single bus request into the pin-level waveform of one cycle on an asynchronous 8-bit NAND flash device. A request carries a cycle kind (command byte, address byte, data write or data read) and, for the three output kinds, the byte to put on the bus. The block then asserts chip enable and places the latch enables and data. It pulses the write or read strobe for a programmable width and holds everything for a fixed recovery interval. It ends with a one-tick done pulse, which also returns the byte captured from the device on reads.

The block runs from a tick clock at twice the system clock rate, so every half-system-clock offset is a whole number of ticks. One system clock is two ticks. Two 4-bit stretch inputs (one for writes, one for reads) widen the active strobe, and each is sampled only when a request is accepted. The controller has four states. IDLE waits for a request and takes IDLE->SETUP on acceptance. SETUP holds enables and data ahead of the strobe and takes SETUP->STROBE when its setup count is met, which for reads also waits for the write-to-read turnaround. STROBE drives the strobe low and takes STROBE->HOLD at the end of the stretched width. HOLD keeps enables and data after the strobe rises and takes HOLD->IDLE after its fixed count, raising done. All pin outputs are registered, and the data bus output enable is low while idle and during reads.

Top module: `nand_strobe_seq`

## Requirements
- R1: After reset, chip enable, write strobe and read strobe are high (inactive), both latch enables, the bus output enable and done are low, and req_ready is high.
- R2: For kinds 0 (command), 1 (address) and 2 (data write), chip enable goes low, the latch enable and the bus output enable go high, and data is driven, all exactly 5 ticks before the write strobe falls.
- R3: The write strobe stays low for exactly 2*(wr_stretch+1) ticks.
- R4: After the write strobe rises, chip enable, the latch enable and the driven byte (equal to req_wdata) are held for exactly 6 ticks, and then chip enable rises.
- R5: For kind 3 (data read) with no recent write, chip enable falls 2 ticks before the read strobe. The read strobe stays low for exactly 2*(rd_stretch+1) ticks, chip enable is held 6 ticks after it rises, and the bus output enable stays low throughout.
- R6: The byte on nf_dq_in at the tick edge where the read strobe rises is returned on rsp_rdata while rsp_done is high.
- R7: At least 10 ticks pass from a write strobe rising edge to the next read strobe falling edge. A read accepted in the first idle tick after a write falls exactly 10 ticks after that rise.
- R8: The command latch enable is high only for kind 0, the address latch enable only for kind 1, and never both together.
- R9: The stretch value and write byte are sampled when a request is accepted; changing them while a cycle runs has no effect on that cycle.
- R10: req_ready is high only while idle; a request raised while busy is ignored and starts no cycle.
- R11: rsp_done is high for exactly one tick, in the tick where chip enable returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the system clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted on this edge |
| req_kind | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| req_wdata | input | 8 | Byte driven for kinds 0 to 2 |
| wr_stretch | input | 4 | Write strobe stretch in system clocks |
| rd_stretch | input | 4 | Read strobe stretch in system clocks |
| rsp_done | output | 1 | One-tick end-of-cycle pulse |
| rsp_rdata | output | 8 | Byte captured on the last read |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_out | output | 8 | Bus output byte |
| nf_dq_oe | output | 1 | Bus output enable |
| nf_dq_in | input | 8 | Bus input byte from the device |

## Verification
The bench sweeps every stretch value for all four cycle kinds and measures each edge offset in ticks against the arithmetic timeline. An off-by-one in a counter limit would show up as a strobe one tick too wide or a hold one tick short. The device model presents valid read data only while the read strobe is low, so a capture one tick late returns the inverted byte. A read issued in the first idle tick after a write checks the turnaround: without it, the read strobe would fall 9 ticks after the write strobe rose. Requests raised while busy, and stretch or data inputs changed mid-cycle, must leave the running cycle's width, data and done count untouched.

// File: rtl/nfseq_pkg.sv
package nfseq_pkg;

    typedef enum logic [1:0] {
        K_CMD   = 2'd0,
        K_ADDR  = 2'd1,
        K_WRITE = 2'd2,
        K_READ  = 2'd3
    } op_kind_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SETUP,
        S_STROBE,
        S_HOLD
    } seq_state_t;

endpackage

// File: rtl/nfseq_tick_cnt.sv
module nfseq_tick_cnt #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/nfseq_gap_track.sv
module nfseq_gap_track #(
    parameter int TURN_T = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mark,
    output logic gap_ok
);
    localparam int GW = $clog2(TURN_T + 1);
    localparam logic [GW-1:0] SAT = GW'(TURN_T);
    localparam logic [GW-1:0] LIM = GW'(TURN_T - 1);

    logic [GW-1:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= SAT;
        end else if (mark) begin
            since_q <= '0;
        end else if (since_q != SAT) begin
            since_q <= since_q + 1'b1;
        end
    end

    assign gap_ok = (since_q >= LIM);
endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
    import nfseq_pkg::*;
#(
    parameter int DW         = 8,
    parameter int SW         = 4,
    parameter int WR_SETUP_T = 5,
    parameter int RD_SETUP_T = 2,
    parameter int HOLD_T     = 6,
    parameter int TURN_T     = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_kind,
    input  logic [DW-1:0] req_wdata,
    input  logic [SW-1:0] wr_stretch,
    input  logic [SW-1:0] rd_stretch,
    output logic          rsp_done,
    output logic [DW-1:0] rsp_rdata,
    output logic          nf_ce_n,
    output logic          nf_cle,
    output logic          nf_ale,
    output logic          nf_we_n,
    output logic          nf_re_n,
    output logic [DW-1:0] nf_dq_out,
    output logic          nf_dq_oe,
    input  logic [DW-1:0] nf_dq_in
);
    localparam int MAXLEN = 2 ** (SW + 1);
    localparam int CW     = $clog2(MAXLEN + TURN_T + WR_SETUP_T + HOLD_T + 1);
    localparam logic [CW-1:0] WR_LIM   = CW'(WR_SETUP_T - 1);
    localparam logic [CW-1:0] RD_LIM   = CW'(RD_SETUP_T - 1);
    localparam logic [CW-1:0] HOLD_LIM = CW'(HOLD_T - 1);

    seq_state_t    state_q, state_n;
    op_kind_t      kind_q, kind_n;
    logic [DW-1:0] wdata_q, wdata_n;
    logic [CW-1:0] len_q;
    logic [CW-1:0] cnt;
    logic [CW-1:0] setup_lim;
    logic [SW-1:0] sel_dly;
    logic          cnt_clr;
    logic          gap_ok;
    logic          wr_rise;
    logic          accept;

    nfseq_tick_cnt #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .cnt   (cnt)
    );

    nfseq_gap_track #(.TURN_T(TURN_T)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .mark   (wr_rise),
        .gap_ok (gap_ok)
    );

    assign req_ready = (state_q == S_IDLE);
    assign accept    = req_ready && req_valid;
    assign setup_lim = (kind_q == K_READ) ? RD_LIM : WR_LIM;
    assign kind_n    = accept ? op_kind_t'(req_kind) : kind_q;
    assign wdata_n   = accept ? req_wdata : wdata_q;
    assign sel_dly   = (op_kind_t'(req_kind) == K_READ) ? rd_stretch : wr_stretch;

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE:   if (req_valid) state_n = S_SETUP;
            S_SETUP:  if (cnt >= setup_lim && (kind_q != K_READ || gap_ok)) state_n = S_STROBE;
            S_STROBE: if (cnt == len_q - CW'(1)) state_n = S_HOLD;
            S_HOLD:   if (cnt == HOLD_LIM) state_n = S_IDLE;
        endcase
    end

    assign cnt_clr = (state_n != state_q);
    assign wr_rise = (state_q == S_STROBE) && (state_n == S_HOLD) && (kind_q != K_READ);

    // state register and per-cycle captures
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            kind_q  <= K_CMD;
            wdata_q <= '0;
            len_q   <= CW'(2);
        end else begin
            state_q <= state_n;
            kind_q  <= kind_n;
            wdata_q <= wdata_n;
            if (accept) begin
                len_q <= CW'({sel_dly, 1'b0}) + CW'(2);
            end
        end
    end

    // registered pin and response outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nf_ce_n   <= 1'b1;
            nf_cle    <= 1'b0;
            nf_ale    <= 1'b0;
            nf_we_n   <= 1'b1;
            nf_re_n   <= 1'b1;
            nf_dq_out <= '0;
            nf_dq_oe  <= 1'b0;
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            nf_ce_n   <= (state_n == S_IDLE);
            nf_cle    <= (state_n != S_IDLE) && (kind_n == K_CMD);
            nf_ale    <= (state_n != S_IDLE) && (kind_n == K_ADDR);
            nf_we_n   <= !((state_n == S_STROBE) && (kind_n != K_READ));
            nf_re_n   <= !((state_n == S_STROBE) && (kind_n == K_READ));
            nf_dq_oe  <= (state_n != S_IDLE) && (kind_n != K_READ);
            nf_dq_out <= ((state_n != S_IDLE) && (kind_n != K_READ)) ? wdata_n : '0;
            rsp_done  <= (state_q == S_HOLD) && (state_n == S_IDLE);
            if ((state_q == S_STROBE) && (state_n == S_HOLD) && (kind_q == K_READ)) begin
                rsp_rdata <= nf_dq_in;
            end
        end
    end
endmodule

// File: rtl/nfseq_checker.sv
module nfseq_checker #(
    parameter int DW     = 8,
    parameter int TURN_T = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rsp_done,
    input logic          nf_ce_n,
    input logic          nf_cle,
    input logic          nf_ale,
    input logic          nf_we_n,
    input logic          nf_re_n,
    input logic [DW-1:0] nf_dq_out,
    input logic          nf_dq_oe
);
    localparam int GW = $clog2(TURN_T + 1);

    logic [GW-1:0] since_we;
    logic          we_prev, re_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_we <= GW'(TURN_T);
            we_prev  <= 1'b1;
            re_prev  <= 1'b1;
        end else begin
            we_prev <= nf_we_n;
            re_prev <= nf_re_n;
            if (nf_we_n && !we_prev) begin
                since_we <= '0;
            end else if (since_we != GW'(TURN_T)) begin
                since_we <= since_we + 1'b1;
            end
        end
    end

    AST_STROBE_HAS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (!nf_we_n || !nf_re_n) |-> !nf_ce_n); // R2
    AST_WE_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_we_n |-> nf_dq_oe); // R2
    AST_BUS_OFF_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_re_n |-> !nf_dq_oe); // R5
    AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (nf_dq_oe && $past(nf_dq_oe)) |-> $stable(nf_dq_out)); // R4
    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_cle && nf_ale)); // R8
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        (re_prev && !nf_re_n) |-> (since_we >= GW'(TURN_T - 1))); // R7
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_ce_n |-> !req_ready); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R11
endmodule

bind nand_strobe_seq nfseq_checker #(.DW(DW), .TURN_T(TURN_T)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .nf_ce_n   (nf_ce_n),
    .nf_cle    (nf_cle),
    .nf_ale    (nf_ale),
    .nf_we_n   (nf_we_n),
    .nf_re_n   (nf_re_n),
    .nf_dq_out (nf_dq_out),
    .nf_dq_oe  (nf_dq_oe)
);

// File: tb/test_nand_strobe_seq.sv
module test_nand_strobe_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_kind = 2'd0;
    logic [7:0] req_wdata = 8'h00;
    logic [3:0] wr_stretch = 4'd0;
    logic [3:0] rd_stretch = 4'd0;
    logic       rsp_done;
    logic [7:0] rsp_rdata;
    logic       nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
    logic [7:0] nf_dq_out;
    logic [7:0] nf_dq_in = 8'h00;
    logic [7:0] pat = 8'h00;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    nand_strobe_seq i_nand_strobe_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_wdata(req_wdata), .wr_stretch(wr_stretch),
        .rd_stretch(rd_stretch), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
        .nf_re_n(nf_re_n), .nf_dq_out(nf_dq_out), .nf_dq_oe(nf_dq_oe),
        .nf_dq_in(nf_dq_in)
    );

    // monitor and device model, sampled at the falling edge
    int tk = 0;
    int t_cef, t_wef, t_wer, t_ref, t_rer, t_cer, t_done;
    int re_falls = 0, done_cnt = 0;
    logic cle_ce, ale_ce, oe_ce, cle_wer, ale_wer, oe_wer, oe_rd;
    logic [7:0] dq_ce, dq_wer, rdata_s;
    logic p_ce = 1'b1, p_we = 1'b1, p_re = 1'b1;

    always @(negedge clk) begin
        tk++;
        if (p_ce && !nf_ce_n) begin
            t_cef = tk; cle_ce = nf_cle; ale_ce = nf_ale; oe_ce = nf_dq_oe;
            dq_ce = nf_dq_out; oe_rd = 1'b0;
        end
        if (!p_ce && nf_ce_n) t_cer = tk;
        if (p_we && !nf_we_n) t_wef = tk;
        if (!p_we && nf_we_n) begin
            t_wer = tk; cle_wer = nf_cle; ale_wer = nf_ale; oe_wer = nf_dq_oe; dq_wer = nf_dq_out;
        end
        if (p_re && !nf_re_n) begin t_ref = tk; re_falls++; end
        if (!p_re && nf_re_n) t_rer = tk;
        if (!nf_ce_n && nf_dq_oe && !nf_re_n) oe_rd = 1'b1;
        if (rsp_done) begin done_cnt++; t_done = tk; rdata_s = rsp_rdata; end
        p_ce = nf_ce_n; p_we = nf_we_n; p_re = nf_re_n;
        nf_dq_in = nf_re_n ? ~pat : pat;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_ge(input string req, input int act, input int lo);
        n_chk++;
        if (act < lo) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected>=%0d", req, act, lo);
        end
    endtask

    task automatic issue(input logic [1:0] k, input logic [7:0] d,
                         input logic [3:0] w, input logic [3:0] r);
        while (!req_ready) begin @(negedge clk); #1; end
        req_kind = k; req_wdata = d; wr_stretch = w; rd_stretch = r; req_valid = 1'b1;
        @(negedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input int dc);
        while (done_cnt == dc) begin @(negedge clk); #1; end
    endtask

    task automatic check_write(input int k, input logic [7:0] d, input int w);
        chk("R2 ce-to-we", t_wef - t_cef, 5);
        chk("R2 oe at ce", oe_ce, 1);
        chk("R2 data at ce", dq_ce, d);
        chk("R8 cle at ce", cle_ce, (k == 0));
        chk("R8 ale at ce", ale_ce, (k == 1));
        chk("R3 we width", t_wer - t_wef, 2 * (w + 1));
        chk("R4 ce hold", t_cer - t_wer, 6);
        chk("R4 data at we rise", dq_wer, d);
        chk("R4 oe at we rise", oe_wer, 1);
        chk("R8 cle at we rise", cle_wer, (k == 0));
        chk("R8 ale at we rise", ale_wer, (k == 1));
        chk("R11 done with ce rise", t_done, t_cer);
    endtask

    task automatic check_read(input int r, input logic [7:0] p);
        chk("R5 ce-to-re", t_ref - t_cef, 2);
        chk("R5 re width", t_rer - t_ref, 2 * (r + 1));
        chk("R5 ce hold", t_cer - t_rer, 6);
        chk("R5 oe during read", oe_rd | oe_ce, 0);
        chk("R8 latches in read", cle_ce | ale_ce, 0);
        chk("R6 read data", rdata_s, p);
        chk("R11 done with ce rise", t_done, t_cer);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 ce_n", nf_ce_n, 1);
        chk("R1 we_n", nf_we_n, 1);
        chk("R1 re_n", nf_re_n, 1);
        chk("R1 latches", nf_cle | nf_ale, 0);
        chk("R1 oe", nf_dq_oe, 0);
        chk("R1 done", rsp_done, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 ready", req_ready, 1);

        // reads over every stretch, no prior write
        for (int r = 0; r < 16; r++) begin
            int dc;
            dc = done_cnt;
            pat = 8'(8'h11 * r + 8'h07);
            issue(2'd3, 8'h00, 4'd0, 4'(r));
            wait_done(dc);
            check_read(r, pat);
        end

        // command, address, data write over every stretch
        for (int k = 0; k < 3; k++) begin
            for (int w = 0; w < 16; w++) begin
                int dc;
                logic [7:0] d;
                dc = done_cnt;
                d = 8'(8'h5A ^ (k * 16 + w));
                issue(2'(k), d, 4'(w), 4'd0);
                wait_done(dc);
                check_write(k, d, w);
            end
        end

        // R7 write followed at once by a read
        begin
            int dc;
            dc = done_cnt;
            issue(2'd2, 8'hC3, 4'd0, 4'd0);
            wait_done(dc);
            dc = done_cnt;
            pat = 8'h96;
            issue(2'd3, 8'h00, 4'd0, 4'd1);
            wait_done(dc);
            chk_ge("R7 turnaround min", t_ref - t_wer, 10);
            chk("R7 turnaround exact", t_ref - t_wer, 10);
            chk("R6 read after write", rdata_s, 8'h96);
        end

        // R10 request while busy is ignored
        begin
            int dc, rf;
            dc = done_cnt;
            rf = re_falls;
            issue(2'd2, 8'h3C, 4'd3, 4'd0);
            req_kind = 2'd3; req_valid = 1'b1;
            for (int i = 0; i < 4; i++) begin
                chk("R10 not ready while busy", req_ready, 0);
                @(negedge clk); #1;
            end
            req_valid = 1'b0;
            wait_done(dc);
            repeat (3) @(negedge clk);
            #1;
            chk("R10 no read started", re_falls, rf);
            chk("R10 single done", done_cnt, dc + 1);
            chk("R10 width kept", t_wer - t_wef, 8);
            chk("R10 ready after", req_ready, 1);
        end

        // R9 stretch and data changed mid-cycle
        begin
            int dc;
            dc = done_cnt;
            issue(2'd2, 8'hA7, 4'd2, 4'd0);
            wr_stretch = 4'd15; req_wdata = 8'h00;
            wait_done(dc);
            chk("R9 write width sampled", t_wer - t_wef, 6);
            chk("R9 write data sampled", dq_wer, 8'hA7);
            dc = done_cnt;
            pat = 8'h4E;
            issue(2'd3, 8'h00, 4'd0, 4'd1);
            rd_stretch = 4'd12;
            wait_done(dc);
            chk("R9 read width sampled", t_rer - t_ref, 4);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(negedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule